// File: doc/BRIEF.md
# UART Status Flag Register

This block keeps the sticky status and error flags of a serial port and presents them as one 8-bit readable status byte and one error interrupt flag. The receiver, transmitter, collision detector and auto-baud logic report events as one-cycle pulses. The block accepts each event only in the frame-format mode where that event has meaning. Once a flag is set, it holds until software clears it.

Software clears a flag by writing a one to its bit. A zero in a written bit leaves that flag unchanged. When the receiver is switched off, all receive-related error flags clear together. The shared error interrupt flag has its own write-one-to-clear select and is independent of the individual flags. The clear-to-send bit is not stored: it shows the live pin level whenever hardware flow control is selected.

Top module: `uart_flag_reg`

## Requirements
- R1: After reset, the status byte and the error interrupt flag are both zero.
- R2: The status byte has this layout: bit 7 iteration limit, bit 6 transmitter empty, bit 5 collision, bit 4 bad sync, bit 3 clear-to-send, bit 2 overflow, bit 1 frame error, bit 0 parity error. A status write (`reg_wr_en`=1, `reg_sel`=0) clears each flag whose data bit is 1. It leaves each flag whose data bit is 0 unchanged.
- R3: While `rx_enable` is 0, bits 7, 5, 4, 2, 1 and 0 clear on the next edge and cannot set. Bit 6 and the error interrupt flag are not affected by `rx_enable`.
- R4: Any accepted event on bit 7, 5, 4, 2, 1 or 0 sets `err_irq`. Only a write with `reg_sel`=1 and data bit 0 = 1 clears it. Clearing the status flags does not clear it.
- R5: Bit 6 sets only when `fmt_mode`=2 (host mode), `ev_tx_done` pulses and `tx_hold_empty`=1. Bit 6 reads 0 in any other mode.
- R6: The parity flag sets only when `fmt_mode` is 1, 5 or 7. The iteration flag sets only when `fmt_mode` is 7.
- R7: The bad-sync flag sets on `ev_sync_rx` only when `fmt_mode` is 4 or 5 and `sync_byte` is not 0x55.
- R8: The collision flag sets only while `coll_det_en`=1. The overflow and frame-error flags set in every mode.
- R9: Bit 3 reads `cts_pin` when `flow_ctrl_en`=1 and reads 0 otherwise. Writes to bit 3 have no effect.
- R10: If a set event and a write-one clear hit the same flag, or the error interrupt flag, in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_mode | input | 3 | Frame-format mode code |
| rx_enable | input | 1 | Receiver enabled |
| coll_det_en | input | 1 | Collision detection enabled |
| flow_ctrl_en | input | 1 | Hardware flow control selected |
| cts_pin | input | 1 | Live clear-to-send pin level |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| ev_iter | input | 1 | Repetition limit reached pulse |
| ev_tx_done | input | 1 | Transmission finished pulse |
| ev_coll | input | 1 | Collision detected pulse |
| ev_sync_rx | input | 1 | Sync byte received pulse |
| sync_byte | input | 8 | Received sync byte value |
| ev_ovf | input | 1 | Receive overflow pulse |
| ev_ferr | input | 1 | Frame error pulse |
| ev_perr | input | 1 | Parity error pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status byte, 1 selects the error interrupt flag |
| reg_wdata | input | 8 | Write data |
| rd_status | output | 8 | Status byte |
| err_irq | output | 1 | Shared error interrupt flag |

## Verification
Each event pulse or write is registered once. Its effect therefore appears on `rd_status` and `err_irq` just after the next rising edge. The clear-to-send bit follows its pins with no delay. The bench drives every stimulus on a falling edge and then waits through one rising edge. It samples at the following falling edge, which is the first point where the registered result is due. It checks the clear-to-send bit in the same low phase in which the pins change.

// File: rtl/uart_flag_reg.sv
module uart_flag_reg #(
  parameter int          FMT_W        = 3,
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  SYNC_PATTERN = 8'h55,
  parameter int          FMT_PAR_A    = 1,
  parameter int          FMT_HOST     = 2,
  parameter int          FMT_ABAUD_A  = 4,
  parameter int          FMT_ABAUD_B  = 5,
  parameter int          FMT_SMART    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_mode,
  input  logic              rx_enable,
  input  logic              coll_det_en,
  input  logic              flow_ctrl_en,
  input  logic              cts_pin,
  input  logic              tx_hold_empty,
  input  logic              ev_iter,
  input  logic              ev_tx_done,
  input  logic              ev_coll,
  input  logic              ev_sync_rx,
  input  logic [7:0]        sync_byte,
  input  logic              ev_ovf,
  input  logic              ev_ferr,
  input  logic              ev_perr,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_status,
  output logic              err_irq
);
  localparam int BIT_ITER = 7, BIT_TXE = 6, BIT_COLL = 5, BIT_SYNC = 4;
  localparam int BIT_CTS  = 3, BIT_OVF = 2, BIT_FERR = 1, BIT_PERR = 0;
  localparam logic [DATA_W-1:0] ERR_MASK = DATA_W'((1 << BIT_ITER) | (1 << BIT_COLL) |
      (1 << BIT_SYNC) | (1 << BIT_OVF) | (1 << BIT_FERR) | (1 << BIT_PERR));

  logic              in_host, in_abaud, par_ok, iter_ok;
  logic              wr_status, wr_irq;
  logic [DATA_W-1:0] set_raw, set_eff, clr_mask, flags_q, flags_d;

  assign in_host  = (fmt_mode == FMT_W'(FMT_HOST));
  assign in_abaud = (fmt_mode == FMT_W'(FMT_ABAUD_A)) || (fmt_mode == FMT_W'(FMT_ABAUD_B));
  assign iter_ok  = (fmt_mode == FMT_W'(FMT_SMART));
  assign par_ok   = (fmt_mode == FMT_W'(FMT_PAR_A)) || (fmt_mode == FMT_W'(FMT_ABAUD_B)) || iter_ok;

  assign wr_status = reg_wr_en && !reg_sel;
  assign wr_irq    = reg_wr_en && reg_sel;

  always_comb begin
    set_raw           = '0;
    set_raw[BIT_ITER] = ev_iter && iter_ok;
    set_raw[BIT_TXE]  = ev_tx_done && tx_hold_empty && in_host;
    set_raw[BIT_COLL] = ev_coll && coll_det_en;
    set_raw[BIT_SYNC] = ev_sync_rx && in_abaud && (sync_byte != SYNC_PATTERN);
    set_raw[BIT_OVF]  = ev_ovf;
    set_raw[BIT_FERR] = ev_ferr;
    set_raw[BIT_PERR] = ev_perr && par_ok;
  end

  assign set_eff  = rx_enable ? set_raw : (set_raw & ~ERR_MASK);
  assign clr_mask = wr_status ? reg_wdata : '0;

  always_comb begin
    flags_d = (flags_q & ~clr_mask) | set_eff;
    if (!rx_enable) flags_d = flags_d & ~ERR_MASK;
    if (!in_host)   flags_d[BIT_TXE] = 1'b0;
    flags_d[BIT_CTS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      err_irq <= 1'b0;
    end else begin
      flags_q <= flags_d;
      err_irq <= (err_irq && !(wr_irq && reg_wdata[0])) || (|(set_eff & ERR_MASK));
    end
  end

  assign rd_status = flags_q | (DATA_W'(flow_ctrl_en && cts_pin) << BIT_CTS);

  // R2: a zero in the write data leaves the frame-error flag held
  a_r2_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !reg_wdata[BIT_FERR] && rx_enable && rd_status[BIT_FERR]) |=> rd_status[BIT_FERR]);

  // R3: receiver disable empties the receive error flags
  a_r3_rx_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> ((rd_status & ERR_MASK) == '0));

  // R4: an accepted frame error raises the interrupt flag
  a_r4_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && ev_ferr) |=> err_irq);

  // R5: outside host mode the transmitter-empty bit is zero on the next cycle
  a_r5_txe_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    !in_host |=> !rd_status[BIT_TXE]);

  // R10: a set coinciding with a clear leaves the overflow flag set
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && ev_ovf && wr_status && reg_wdata[BIT_OVF]) |=> rd_status[BIT_OVF]);

  // R1: interrupt flag cannot rise without an error event
  a_r1_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_irq && !(rx_enable && (ev_iter || ev_coll || ev_sync_rx || ev_ovf || ev_ferr || ev_perr)))
      |=> !err_irq);
endmodule

// File: tb/test_uart_flag_reg.sv
`timescale 1ns/100ps
module test_uart_flag_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] fmt_mode = '0;
  logic rx_enable = 1'b1, coll_det_en = 1'b1, flow_ctrl_en = 1'b0, cts_pin = 1'b0;
  logic tx_hold_empty = 1'b1;
  logic ev_iter = 0, ev_tx_done = 0, ev_coll = 0, ev_sync_rx = 0, ev_ovf = 0, ev_ferr = 0, ev_perr = 0;
  logic [7:0] sync_byte = 8'h55;
  logic reg_wr_en = 0, reg_sel = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_status;
  logic err_irq;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_flag_reg i_uart_flag_reg (.*);

  // {fmt[2:0], ev{iter,txdone,coll,sync,ovf,ferr,perr}[6:0], sync_byte[7:0], expected[7:0]}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {3'd0, 7'b0000010, 8'h55, 8'h02},
    {3'd0, 7'b0000001, 8'h55, 8'h00},
    {3'd1, 7'b0000001, 8'h55, 8'h01},
    {3'd5, 7'b0001001, 8'h12, 8'h11},
    {3'd4, 7'b0001000, 8'h55, 8'h00},
    {3'd4, 7'b0001000, 8'hAA, 8'h10},
    {3'd7, 7'b1000000, 8'h55, 8'h80},
    {3'd0, 7'b1000000, 8'h55, 8'h00},
    {3'd2, 7'b0100000, 8'h55, 8'h40},
    {3'd0, 7'b0100000, 8'h55, 8'h00},
    {3'd0, 7'b0010000, 8'h55, 8'h20},
    {3'd0, 7'b0000100, 8'h55, 8'h04},
    {3'd7, 7'b0000111, 8'h55, 8'h07}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr_en = 0; reg_wdata = '0;
  endtask

  task automatic events(input logic [6:0] e);
    {ev_iter, ev_tx_done, ev_coll, ev_sync_rx, ev_ovf, ev_ferr, ev_perr} = e;
    step();
    {ev_iter, ev_tx_done, ev_coll, ev_sync_rx, ev_ovf, ev_ferr, ev_perr} = '0;
  endtask

  task automatic clear_all();
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h01);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 status at reset", rd_status, 8'h00);
    chk("R1 irq at reset", {7'd0, err_irq}, 8'h00);
    rst_n = 1;
    step();
    chk("R1 status after release", rd_status, 8'h00);

    for (int i = 0; i < NV; i++) begin
      clear_all();
      fmt_mode  = VEC[i][25:23];
      sync_byte = VEC[i][15:8];
      step();
      events(VEC[i][22:16]);
      chk($sformatf("R5 R6 R7 R8 vector %0d status", i), rd_status, VEC[i][7:0]);
      chk($sformatf("R4 vector %0d irq", i), {7'd0, err_irq},
          {7'd0, |(VEC[i][7:0] & 8'hB7)});
    end

    // R2: write zero keeps, write one clears only its bit
    fmt_mode = 3'd0;
    clear_all();
    events(7'b0000110);
    wr(1'b0, 8'h00);
    chk("R2 write zero no effect", rd_status, 8'h06);
    wr(1'b0, 8'h02);
    chk("R2 write one clears frame bit only", rd_status, 8'h04);

    // R4: status clear leaves irq; irq select clears it
    wr(1'b0, 8'hFF);
    chk("R4 status cleared", rd_status, 8'h00);
    chk("R4 irq survives status clear", {7'd0, err_irq}, 8'h01);
    wr(1'b1, 8'h00);
    chk("R4 irq write zero no effect", {7'd0, err_irq}, 8'h01);
    wr(1'b1, 8'h01);
    chk("R4 irq write one clears", {7'd0, err_irq}, 8'h00);

    // R3: receiver disable clears error flags, keeps txe and irq
    fmt_mode = 3'd2;
    step();
    events(7'b0110110);
    chk("R3 flags before disable", rd_status, 8'h66);
    rx_enable = 0;
    step();
    chk("R3 disable clears error flags keeps txe", rd_status, 8'h40);
    chk("R3 irq kept on disable", {7'd0, err_irq}, 8'h01);
    wr(1'b1, 8'h01);
    events(7'b0000010);
    chk("R3 no set while disabled", rd_status, 8'h40);
    chk("R3 no irq while disabled", {7'd0, err_irq}, 8'h00);
    rx_enable = 1;

    // R5: leaving host mode zeroes txe; tx holding not empty blocks it
    fmt_mode = 3'd0;
    step();
    chk("R5 txe zero outside host", rd_status, 8'h00);
    fmt_mode = 3'd2; tx_hold_empty = 0;
    step();
    events(7'b0100000);
    chk("R5 txe needs empty holding", rd_status, 8'h00);
    tx_hold_empty = 1;

    // R8: collision ignored with detection off
    coll_det_en = 0;
    events(7'b0010000);
    chk("R8 collision ignored when disabled", rd_status, 8'h00);
    coll_det_en = 1;

    // R9: live clear-to-send bit
    fmt_mode = 3'd0;
    cts_pin = 1;
    #1 chk("R9 cts masked without flow control", rd_status, 8'h00);
    flow_ctrl_en = 1;
    #1 chk("R9 cts follows pin", rd_status, 8'h08);
    wr(1'b0, 8'h08);
    chk("R9 cts write ignored", rd_status, 8'h08);
    cts_pin = 0;
    #1 chk("R9 cts follows pin low", rd_status, 8'h00);
    flow_ctrl_en = 0;

    // R10: set and clear in the same cycle
    clear_all();
    ev_ovf = 1; reg_wr_en = 1; reg_sel = 0; reg_wdata = 8'h04;
    step();
    ev_ovf = 0; reg_wr_en = 0; reg_wdata = '0;
    chk("R10 set beats status clear", rd_status, 8'h04);
    ev_ferr = 1; reg_wr_en = 1; reg_sel = 1; reg_wdata = 8'h01;
    step();
    ev_ferr = 0; reg_wr_en = 0; reg_wdata = '0;
    chk("R10 set beats irq clear", {7'd0, err_irq}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule